// File: doc/BRIEF.md
# Circular Event Queue Appender

This block appends one 32-bit event word to a circular event queue held in memory. The caller presents the queue's current descriptor state (base address, size code, write index, generation bit and a generation-flipped flag) together with the event payload. The block issues a single memory write carrying the formatted entry, waits for the write response, and then presents the descriptor fields as they must be written back.

Every stored entry carries the producer's generation bit in its most significant bit, in place of payload bit 31. The generation inverts each time the write index wraps to zero. A consumer that remembers the generation it expects can therefore tell fresh entries from stale ones without reading a shared producer pointer. A failed memory write leaves the descriptor state exactly as it was presented.

The queue holds 2^(size_code+10) entries. The parameter `MAX_SZ` sets the largest size code the index register can represent.

Top module: `evq_append`

## Requirements
- R1: `ev_ready` is high only while the block is idle. An event is accepted on a clock edge where `ev_valid` and `ev_ready` are both high. `ev_ready` then stays low, and no further event is taken, until the cycle after `done`. `ev_ready` and `mw_valid` are never high together.
- R2: The write address equals `base_addr + 4*m`, where `m` is `cur_index` reduced modulo the number of entries.
- R3: The stored entry word carries `cur_gen` in bit 31 and `ev_data[30:0]` in bits 30:0. It is driven big-endian on `mw_data`: entry bits 31:24 go on `mw_data[7:0]`, bits 23:16 on `mw_data[15:8]`, bits 15:8 on `mw_data[23:16]`, and bits 7:0 on `mw_data[31:24]`.
- R4: The number of entries is 2^(s+10), where s is `size_code` clamped to `MAX_SZ`. After a successful write, `upd_index = (m+1) mod entries`.
- R5: When the new index is 0, `upd_gen = ~cur_gen` and `upd_flipped` takes the new generation value. Otherwise `upd_gen = cur_gen` and `upd_flipped = cur_flipped`.
- R6: When the write response has `mw_resp_err` high, `done_err` is high with `done`, and `upd_index`, `upd_gen` and `upd_flipped` equal the accepted `cur_index`, `cur_gen` and `cur_flipped`.
- R7: `done` is a single-cycle pulse in the cycle after the write response. The update outputs are valid from that pulse until the next accepted event.
- R8: While `mw_valid` is high and `mw_ready` is low, `mw_valid`, `mw_addr` and `mw_data` hold their values in the next cycle.
- R9: After reset, `ev_ready` is 1, `mw_valid` and `done` are 0, and the update outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Block idle, event can be taken |
| ev_data | input | 32 | Event payload |
| base_addr | input | ADDR_W | Queue base byte address |
| size_code | input | 4 | Queue size code |
| cur_index | input | MAX_SZ+10 | Current write index |
| cur_gen | input | 1 | Current generation bit |
| cur_flipped | input | 1 | Current generation-flipped flag |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory write accepted |
| mw_addr | output | ADDR_W | Write byte address |
| mw_data | output | 32 | Big-endian entry word |
| mw_resp_valid | input | 1 | Write response present |
| mw_resp_err | input | 1 | Write failed |
| done | output | 1 | Descriptor update ready (pulse) |
| done_err | output | 1 | Update was aborted by a memory error |
| upd_index | output | MAX_SZ+10 | Index to write back |
| upd_gen | output | 1 | Generation to write back |
| upd_flipped | output | 1 | Generation-flipped flag to write back |

## Verification
The bench builds the block with `MAX_SZ=1` and `ADDR_W=32`. With those values queues of 1024 and 2048 entries are small enough to step through every index, across at least one wrap in each direction of the generation bit. The same build makes a size code above the limit cheap to exercise, so clamping, index masking of out-of-range indices and wrap at the largest supported queue are all reached. Memory stalls of zero to two cycles and periodic error responses are mixed into the sweep.

// File: rtl/evq_append.sv
module evq_append #(
  parameter int ADDR_W = 64,
  parameter int MAX_SZ = 15,
  localparam int IDX_W = MAX_SZ + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [31:0]       ev_data,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [3:0]        size_code,
  input  logic [IDX_W-1:0]  cur_index,
  input  logic              cur_gen,
  input  logic              cur_flipped,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [31:0]       mw_data,
  input  logic              mw_resp_valid,
  input  logic              mw_resp_err,
  output logic              done,
  output logic              done_err,
  output logic [IDX_W-1:0]  upd_index,
  output logic              upd_gen,
  output logic              upd_flipped
);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RSP, S_DONE} st_t;
  st_t st;

  logic [3:0]       szc;
  logic [4:0]       shamt;
  logic [IDX_W-1:0] mask, midx, inc;
  logic             wrap, take;
  logic [31:0]      entry;

  logic [IDX_W-1:0] nxt_idx;
  logic             nxt_gen, nxt_flp;

  assign szc   = (int'(size_code) > MAX_SZ) ? 4'(MAX_SZ) : size_code;
  assign shamt = {1'b0, szc} + 5'd10;
  assign mask  = ~({IDX_W{1'b1}} << shamt);
  assign midx  = cur_index & mask;
  assign inc   = (midx + 1'b1) & mask;
  assign wrap  = (inc == '0);
  assign entry = {cur_gen, ev_data[30:0]};

  assign ev_ready = (st == S_IDLE);
  assign mw_valid = (st == S_WR);
  assign done     = (st == S_DONE);
  assign take     = ev_valid && ev_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      mw_addr     <= '0;
      mw_data     <= '0;
      nxt_idx     <= '0;
      nxt_gen     <= 1'b0;
      nxt_flp     <= 1'b0;
      upd_index   <= '0;
      upd_gen     <= 1'b0;
      upd_flipped <= 1'b0;
      done_err    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          st          <= S_WR;
          mw_addr     <= base_addr + ADDR_W'({midx, 2'b00});
          mw_data     <= {entry[7:0], entry[15:8], entry[23:16], entry[31:24]};
          nxt_idx     <= inc;
          nxt_gen     <= wrap ? ~cur_gen : cur_gen;
          nxt_flp     <= wrap ? ~cur_gen : cur_flipped;
          upd_index   <= cur_index;
          upd_gen     <= cur_gen;
          upd_flipped <= cur_flipped;
          done_err    <= 1'b0;
        end
        S_WR: if (mw_ready) st <= S_RSP;
        S_RSP: if (mw_resp_valid) begin
          st       <= S_DONE;
          done_err <= mw_resp_err;
          if (!mw_resp_err) begin
            upd_index   <= nxt_idx;
            upd_gen     <= nxt_gen;
            upd_flipped <= nxt_flp;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/evq_append_chk.sv
module evq_append_chk #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_ready,
  input logic              mw_valid,
  input logic              mw_ready,
  input logic [ADDR_W-1:0] mw_addr,
  input logic [31:0]       mw_data,
  input logic              done,
  input logic              done_err,
  input logic [IDX_W-1:0]  upd_index,
  input logic              upd_gen,
  input logic              upd_flipped
);

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_ready && mw_valid));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && ev_ready);

  p_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_err && upd_index == '0 |-> upd_flipped == upd_gen);

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err |-> $stable(upd_index) && $stable(upd_gen) && $stable(upd_flipped));

endmodule

bind evq_append evq_append_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_ready(ev_ready), .mw_valid(mw_valid),
  .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data), .done(done),
  .done_err(done_err), .upd_index(upd_index), .upd_gen(upd_gen),
  .upd_flipped(upd_flipped)
);

// File: tb/tb_evq_append.sv
module tb_evq_append;
  localparam int AW = 32;
  localparam int MS = 1;
  localparam int IW = MS + 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_ready;
  logic [31:0] ev_data = '0;
  logic [AW-1:0] base_addr = '0;
  logic [3:0] size_code = '0;
  logic [IW-1:0] cur_index = '0;
  logic cur_gen = 1'b0, cur_flipped = 1'b0;
  logic mw_valid, mw_ready = 1'b0;
  logic [AW-1:0] mw_addr;
  logic [31:0] mw_data;
  logic mw_resp_valid = 1'b0, mw_resp_err = 1'b0;
  logic done, done_err;
  logic [IW-1:0] upd_index;
  logic upd_gen, upd_flipped;

  evq_append #(.ADDR_W(AW), .MAX_SZ(MS)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int m_idx; logic m_gen, m_flp; logic [AW-1:0] m_base;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      fails++;
      $display("FAIL watchdog: act cycles=%0d exp <150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic ev(input int sz, input logic [31:0] d, input bit err, input int stall);
    int ent, mi, ni; logic ng, nf; logic [31:0] ew, eb; logic [AW-1:0] ea;
    ent = 1 << (((sz > MS) ? MS : sz) + 10);
    mi  = m_idx % ent;
    ea  = m_base + AW'(mi * 4);
    ew  = {m_gen, d[30:0]};
    eb  = {ew[7:0], ew[15:8], ew[23:16], ew[31:24]};
    ni  = (mi + 1) % ent;
    ng  = (ni == 0) ? ~m_gen : m_gen;
    nf  = (ni == 0) ? ng : m_flp;
    @(negedge clk);
    chk(ev_ready == 1'b1, "R1 ready idle", ev_ready, 1);
    ev_valid = 1'b1; ev_data = d; size_code = 4'(sz); base_addr = m_base;
    cur_index = IW'(m_idx); cur_gen = m_gen; cur_flipped = m_flp;
    @(negedge clk);
    ev_valid = 1'b0;
    chk(ev_ready == 1'b0, "R1 busy", ev_ready, 0);
    for (int k = 0; k < stall; k++) begin
      chk(mw_valid == 1'b1, "R8 held", mw_valid, 1);
      @(negedge clk);
    end
    chk(mw_valid == 1'b1, "R8 valid", mw_valid, 1);
    chk(mw_addr == ea, "R2 addr", mw_addr, ea);
    chk(mw_data == eb, "R3 data", mw_data, eb);
    mw_ready = 1'b1;
    @(negedge clk);
    mw_ready = 1'b0;
    chk(mw_valid == 1'b0, "R1 one write", mw_valid, 0);
    mw_resp_valid = 1'b1; mw_resp_err = err;
    @(negedge clk);
    mw_resp_valid = 1'b0; mw_resp_err = 1'b0;
    chk(done == 1'b1, "R7 done", done, 1);
    chk(done_err == err, "R6 done_err", done_err, err);
    if (err) begin
      chk(upd_index == IW'(m_idx) && upd_gen == m_gen && upd_flipped == m_flp,
          "R6 unchanged", {upd_index, upd_gen, upd_flipped}, {IW'(m_idx), m_gen, m_flp});
    end else begin
      chk(upd_index == IW'(ni), "R4 index", upd_index, ni);
      chk(upd_gen == ng && upd_flipped == nf, "R5 gen/flip",
          {upd_gen, upd_flipped}, {ng, nf});
      m_idx = ni; m_gen = ng; m_flp = nf;
    end
    @(negedge clk);
    chk(done == 1'b0 && ev_ready == 1'b1, "R7 pulse", {done, ev_ready}, 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ev_ready == 1'b1 && mw_valid == 1'b0 && done == 1'b0, "R9 reset ctl",
        {ev_ready, mw_valid, done}, 3'b100);
    chk(upd_index == '0 && upd_gen == 1'b0 && upd_flipped == 1'b0, "R9 reset upd",
        {upd_index, upd_gen, upd_flipped}, 0);
    rst_n = 1'b1;
    m_base = 32'h0001_0000; m_idx = 0; m_gen = 1'b1; m_flp = 1'b0;
    for (int n = 0; n < 1100; n++)
      ev(0, 32'h9E37_79B9 * n + 32'h8000_0000, (n % 97) == 96, n % 3);
    m_base = 32'h2000_0F00; m_idx = 2040; m_gen = 1'b0; m_flp = 1'b1;
    for (int n = 0; n < 2100; n++)
      ev(1, 32'h7FFF_0001 ^ (n * 32'h0101_0F0F), (n % 89) == 7, (n + 1) % 3);
    m_base = 32'h0000_4000; m_idx = 2044; m_gen = 1'b1; m_flp = 1'b1;
    for (int n = 0; n < 8; n++) ev(9, 32'hFFFF_FFFF - n, 1'b0, 0);
    m_idx = 1500; m_gen = 1'b0; m_flp = 1'b0;
    for (int n = 0; n < 4; n++) ev(0, 32'h1234_5678 + n, 1'b0, 1);
    finish_run();
  end
endmodule